// File: doc/BRIEF.md
# Issue Latency Scoreboard

This block sits at the issue stage of an in-order pipeline that can present several instructions per cycle. For every architectural register it keeps a small countdown telling how many more cycles must pass before the value being computed for that register can be read. When an instruction issues, the countdown of its destination is loaded from a fixed table indexed by the instruction's class. The table holds one result latency per class, from zero for stores up to twenty for integer divide.

Each cycle, the issue logic presents one candidate per lane, with a class, a destination index and two source indices. Lane 0 is the oldest. The block returns a hold bit per lane. A lane is held when one of its sources is still counting down or when it reads a result produced by an older lane in the same cycle. It is also held when an older lane is held, which keeps issue in order. The block also owns a single memory port, so at most one load, store, prefetch or coprocessor transfer may issue per cycle. Forwarding, the register file and the datapath are not part of the block.

Top module: `lat_scoreboard`

## Requirements
- R1: After reset no register is pending, so a candidate with any source indices is not held.
- R2: An instruction issued in cycle t with a destination other than 0 and a class of latency L holds any later reader of that destination in cycle t+k exactly when k < L. Class codes and latencies: 1 simple integer 2, 2 branch 2, 3 integer multiply 5, 4 integer divide 20, 5 load 5, 6 coprocessor transfer 5, 9 short FP (abs, negate, compare, move) 3, 10 FP convert 5, 11 FP add/multiply/multiply-add 7, 12 FP divide 9, 13 FP square root 15, 14 two-operation macro 4.
- R3: Stores (code 7) and prefetches (code 8) have latency 0: they never mark their destination field pending and never cause a reader to be held, not even in the same cycle.
- R4: Classes 0 and 15 (unknown) have latency 1: a reader in the next cycle is not held, but a younger lane reading that destination in the same cycle is held.
- R5: Register index 0 is never pending and a source of 0 never causes a hold.
- R6: Memory classes are codes 5, 6, 7 and 8. At most one of them issues per cycle: a valid memory lane is held when any older valid lane is also a memory class.
- R7: A younger lane whose source equals the destination (not 0) of a valid older lane with nonzero latency in the same cycle is held.
- R8: A valid lane is held whenever a valid older lane is held.
- R9: A lane that is not valid is never reported as held, and a lane that is not valid has no effect on younger lanes or on any countdown.
- R10: A new writer reloads its destination's countdown from the table, replacing any remaining count. When two lanes write the same destination in one cycle, the younger lane's latency applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | NUM_LANES | Candidate present on each lane (lane 0 oldest) |
| in_class | input | NUM_LANES x 4 | Instruction class code per lane |
| in_dst | input | NUM_LANES x REG_W | Destination register index per lane |
| in_src_a | input | NUM_LANES x REG_W | First source register index per lane |
| in_src_b | input | NUM_LANES x REG_W | Second source register index per lane |
| out_hold | output | NUM_LANES | Lane must not issue this cycle |

## Verification
The bench builds the block with NUM_LANES = 2 and NUM_REGS = 16. Two lanes bring the memory-port conflict, the same-cycle dependency, in-order holding and same-destination ordering within reach. Sixteen registers let each class of the latency table use a fresh destination, and the reader is probed every cycle until the countdown ends. The 20-cycle divide reaches the widest countdown value.

// File: rtl/sb_pkg.sv
package sb_pkg;

  localparam int CLS_W   = 4;
  localparam int MAX_LAT = 20;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  typedef enum logic [CLS_W-1:0] {
    CLS_UNKNOWN  = 4'd0,
    CLS_INT      = 4'd1,
    CLS_BRANCH   = 4'd2,
    CLS_IMUL     = 4'd3,
    CLS_IDIV     = 4'd4,
    CLS_LOAD     = 4'd5,
    CLS_XFER     = 4'd6,
    CLS_STORE    = 4'd7,
    CLS_PREF     = 4'd8,
    CLS_FP_SHORT = 4'd9,
    CLS_FP_CVT   = 4'd10,
    CLS_FP_ARITH = 4'd11,
    CLS_FP_DIV   = 4'd12,
    CLS_FP_SQRT  = 4'd13,
    CLS_MACRO    = 4'd14,
    CLS_RSVD     = 4'd15
  } cls_t;

  function automatic logic [CNT_W-1:0] cls_latency(input logic [CLS_W-1:0] c);
    logic [CNT_W-1:0] lat;
    case (c)
      CLS_INT, CLS_BRANCH:           lat = CNT_W'(2);
      CLS_IMUL:                      lat = CNT_W'(5);
      CLS_IDIV:                      lat = CNT_W'(20);
      CLS_LOAD, CLS_XFER:            lat = CNT_W'(5);
      CLS_STORE, CLS_PREF:           lat = CNT_W'(0);
      CLS_FP_SHORT:                  lat = CNT_W'(3);
      CLS_FP_CVT:                    lat = CNT_W'(5);
      CLS_FP_ARITH:                  lat = CNT_W'(7);
      CLS_FP_DIV:                    lat = CNT_W'(9);
      CLS_FP_SQRT:                   lat = CNT_W'(15);
      CLS_MACRO:                     lat = CNT_W'(4);
      default:                       lat = CNT_W'(1);
    endcase
    return lat;
  endfunction

  function automatic logic cls_is_mem(input logic [CLS_W-1:0] c);
    return (c == CLS_LOAD) || (c == CLS_XFER) || (c == CLS_STORE) || (c == CLS_PREF);
  endfunction

endpackage

// File: rtl/sb_class_decode.sv
module sb_class_decode
  import sb_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  output logic [CNT_W-1:0] reload,
  output logic             writes,
  output logic             is_mem
);

  logic [CNT_W-1:0] lat;

  always_comb begin
    lat    = cls_latency(cls);
    writes = (lat != '0);
    reload = writes ? (lat - CNT_W'(1)) : '0;
    is_mem = cls_is_mem(cls);
  end

endmodule

// File: rtl/sb_reg_timer.sv
module sb_reg_timer
  import sb_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int REG_W     = 5,
  parameter int REG_IDX   = 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_LANES-1:0]              wr_en,
  input  logic [NUM_LANES-1:0][REG_W-1:0]   wr_dst,
  input  logic [NUM_LANES-1:0][CNT_W-1:0]   wr_reload,
  output logic                              pending
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Younger lanes come later in the loop, so they take precedence.
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (cnt_q != '0) begin
      cnt_d  = cnt_q - CNT_W'(1);
      cnt_en = 1'b1;
    end
    for (int l = 0; l < NUM_LANES; l++) begin
      if (wr_en[l] && (wr_dst[l] == REG_W'(REG_IDX))) begin
        cnt_d  = wr_reload[l];
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pending = (cnt_q != '0);

endmodule

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl #(
  parameter int NUM_LANES = 2,
  parameter int NUM_REGS  = 32,
  parameter int REG_W     = 5
) (
  input  logic [NUM_LANES-1:0]              valid,
  input  logic [NUM_LANES-1:0][REG_W-1:0]   dst,
  input  logic [NUM_LANES-1:0][REG_W-1:0]   src_a,
  input  logic [NUM_LANES-1:0][REG_W-1:0]   src_b,
  input  logic [NUM_LANES-1:0]              writes,
  input  logic [NUM_LANES-1:0]              is_mem,
  input  logic [NUM_REGS-1:0]               pend_vec,
  output logic [NUM_LANES-1:0]              hold,
  output logic [NUM_LANES-1:0]              issue
);

  logic [NUM_LANES-1:0] src_busy;
  logic [NUM_LANES-1:0] intra_dep;
  logic [NUM_LANES-1:0] port_clash;

  always_comb begin
    hold       = '0;
    src_busy   = '0;
    intra_dep  = '0;
    port_clash = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      src_busy[i] = pend_vec[src_a[i]] || pend_vec[src_b[i]];
      for (int j = 0; j < i; j++) begin
        if (valid[j] && writes[j] && (dst[j] != '0) &&
            ((src_a[i] == dst[j]) || (src_b[i] == dst[j]))) begin
          intra_dep[i] = 1'b1;
        end
        if (valid[j] && is_mem[j] && is_mem[i]) begin
          port_clash[i] = 1'b1;
        end
        if (valid[j] && hold[j]) begin
          intra_dep[i] = 1'b1;
        end
      end
      hold[i] = valid[i] && (src_busy[i] || intra_dep[i] || port_clash[i]);
    end
    issue = valid & ~hold;
  end

endmodule

// File: rtl/lat_scoreboard.sv
module lat_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int NUM_REGS  = 32,
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_LANES-1:0]              in_valid,
  input  logic [NUM_LANES-1:0][CLS_W-1:0]   in_class,
  input  logic [NUM_LANES-1:0][REG_W-1:0]   in_dst,
  input  logic [NUM_LANES-1:0][REG_W-1:0]   in_src_a,
  input  logic [NUM_LANES-1:0][REG_W-1:0]   in_src_b,
  output logic [NUM_LANES-1:0]              out_hold
);

  logic                             rst_s0;
  logic                             rst_sync_n;
  logic [NUM_LANES-1:0][CNT_W-1:0]  reload;
  logic [NUM_LANES-1:0]             writes;
  logic [NUM_LANES-1:0]             is_mem;
  logic [NUM_LANES-1:0]             issue;
  logic [NUM_LANES-1:0]             wr_en;
  logic [NUM_REGS-1:0]              pend_vec;

  // Reset asserts at once, deasserts two edges after rst_n rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_sync_n <= rst_s0;
    end
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    sb_class_decode u_dec (
      .cls    (in_class[l]),
      .reload (reload[l]),
      .writes (writes[l]),
      .is_mem (is_mem[l])
    );
    assign wr_en[l] = issue[l] && writes[l] && (in_dst[l] != '0);
  end

  sb_issue_ctl #(
    .NUM_LANES (NUM_LANES),
    .NUM_REGS  (NUM_REGS),
    .REG_W     (REG_W)
  ) u_ctl (
    .valid    (in_valid),
    .dst      (in_dst),
    .src_a    (in_src_a),
    .src_b    (in_src_b),
    .writes   (writes),
    .is_mem   (is_mem),
    .pend_vec (pend_vec),
    .hold     (out_hold),
    .issue    (issue)
  );

  assign pend_vec[0] = 1'b0;

  for (genvar r = 1; r < NUM_REGS; r++) begin : g_reg
    sb_reg_timer #(
      .NUM_LANES (NUM_LANES),
      .REG_W     (REG_W),
      .REG_IDX   (r)
    ) u_tmr (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .wr_en     (wr_en),
      .wr_dst    (in_dst),
      .wr_reload (reload),
      .pending   (pend_vec[r])
    );
  end

endmodule

// File: rtl/sb_checker.sv
module sb_checker
  import sb_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int NUM_REGS  = 32,
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int YL       = NUM_LANES - 1
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_LANES-1:0]              valid,
  input logic [NUM_LANES-1:0][CLS_W-1:0]   cls,
  input logic [NUM_LANES-1:0][REG_W-1:0]   dst,
  input logic [NUM_LANES-1:0]              hold,
  input logic [NUM_REGS-1:0]               pend_vec
);

  logic [NUM_LANES-1:0] mem_go;
  always_comb begin
    for (int l = 0; l < NUM_LANES; l++) begin
      mem_go[l] = valid[l] && !hold[l] && cls_is_mem(cls[l]);
    end
  end

  AST_ZERO_NEVER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_vec[0]); // R5

  AST_ONE_MEM_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mem_go) <= 1); // R6

  AST_HOLD_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (hold & ~valid) == '0); // R9

  AST_WRITER_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid[YL] && !hold[YL] && (dst[YL] != '0) && (cls_latency(cls[YL]) > CNT_W'(1)))
    |=> pend_vec[$past(dst[YL])]); // R2

  for (genvar i = 1; i < NUM_LANES; i++) begin : g_order
    AST_IN_ORDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid[i] && valid[i-1] && hold[i-1]) |-> hold[i]); // R8
  end

endmodule

bind lat_scoreboard sb_checker #(
  .NUM_LANES (NUM_LANES),
  .NUM_REGS  (NUM_REGS)
) u_sb_checker (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .valid    (in_valid),
  .cls      (in_class),
  .dst      (in_dst),
  .hold     (out_hold),
  .pend_vec (pend_vec)
);

// File: tb/test_lat_scoreboard.sv
module test_lat_scoreboard;
  import sb_pkg::*;

  localparam int LANES = 2;
  localparam int REGS  = 16;

  logic                        clk;
  logic                        rst_n;
  logic [LANES-1:0]            in_valid;
  logic [LANES-1:0][3:0]       in_class;
  logic [LANES-1:0][3:0]       in_dst;
  logic [LANES-1:0][3:0]       in_src_a;
  logic [LANES-1:0][3:0]       in_src_b;
  logic [LANES-1:0]            out_hold;

  lat_scoreboard #(.NUM_LANES(LANES), .NUM_REGS(REGS)) i_lat_scoreboard (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_class (in_class),
    .in_dst   (in_dst),
    .in_src_a (in_src_a),
    .in_src_b (in_src_b),
    .out_hold (out_hold)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [1:0] exp;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      checks++;
      if (out_hold !== it.exp) begin
        fails++;
        $display("FAIL %s: hold=%b expected=%b", it.tag, out_hold, it.exp);
      end
    end
  end

  task automatic cyc(input logic [1:0] v,
                     input logic [3:0] c0, input logic [3:0] d0,
                     input logic [3:0] a0, input logic [3:0] b0,
                     input logic [3:0] c1, input logic [3:0] d1,
                     input logic [3:0] a1, input logic [3:0] b1,
                     input logic [1:0] exp, input string tag);
    exp_t it;
    @(posedge clk);
    #1;
    in_valid    = v;
    in_class[0] = c0; in_dst[0] = d0; in_src_a[0] = a0; in_src_b[0] = b0;
    in_class[1] = c1; in_dst[1] = d1; in_src_a[1] = a1; in_src_b[1] = b1;
    it.exp = exp;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      in_valid = '0;
    end
  endtask

  // Writer on lane 0, then a reader probes each following cycle.
  task automatic test_lat(input logic [3:0] c, input int lat,
                          input logic [3:0] d, input string tag);
    int last;
    cyc(2'b01, c, d, 4'd0, 4'd0, CLS_INT, 4'd0, 4'd0, 4'd0, 2'b00, tag);
    last = (lat < 1) ? 1 : lat;
    for (int k = 1; k <= last; k++) begin
      logic [3:0] sa;
      logic [3:0] sb;
      sa = (k % 2 == 1) ? d : 4'd0;
      sb = (k % 2 == 1) ? 4'd0 : d;
      cyc(2'b01, CLS_INT, 4'd0, sa, sb, CLS_INT, 4'd0, 4'd0, 4'd0,
          {1'b0, (k < lat)}, tag);
    end
  endtask

  initial begin
    in_valid = '0;
    in_class = '0;
    in_dst   = '0;
    in_src_a = '0;
    in_src_b = '0;
    rst_n    = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: nothing pending after reset
    cyc(2'b11, CLS_INT, 4'd0, 4'd5, 4'd9, CLS_INT, 4'd0, 4'd15, 4'd1, 2'b00, "R1");

    // R2: every nonzero-latency class
    test_lat(CLS_INT,      2,  4'd1,  "R2");
    test_lat(CLS_BRANCH,   2,  4'd2,  "R2");
    test_lat(CLS_IMUL,     5,  4'd3,  "R2");
    test_lat(CLS_IDIV,     20, 4'd4,  "R2");
    test_lat(CLS_LOAD,     5,  4'd5,  "R2");
    test_lat(CLS_XFER,     5,  4'd6,  "R2");
    test_lat(CLS_FP_SHORT, 3,  4'd7,  "R2");
    test_lat(CLS_FP_CVT,   5,  4'd8,  "R2");
    test_lat(CLS_FP_ARITH, 7,  4'd9,  "R2");
    test_lat(CLS_FP_DIV,   9,  4'd10, "R2");
    test_lat(CLS_FP_SQRT,  15, 4'd11, "R2");
    test_lat(CLS_MACRO,    4,  4'd12, "R2");

    // R3: store and prefetch never pend
    test_lat(CLS_STORE, 0, 4'd13, "R3");
    test_lat(CLS_PREF,  0, 4'd14, "R3");
    // R4: unknown classes free next cycle
    test_lat(CLS_UNKNOWN, 1, 4'd15, "R4");
    test_lat(CLS_RSVD,    1, 4'd1,  "R4");

    // R5: register 0 never pending
    cyc(2'b01, CLS_IMUL, 4'd0, 4'd0, 4'd0, CLS_INT, 4'd0, 4'd0, 4'd0, 2'b00, "R5");
    cyc(2'b01, CLS_INT,  4'd0, 4'd0, 4'd0, CLS_INT, 4'd0, 4'd0, 4'd0, 2'b00, "R5");
    cyc(2'b11, CLS_INT,  4'd0, 4'd0, 4'd0, CLS_INT, 4'd0, 4'd0, 4'd0, 2'b00, "R5");

    // R6: single memory port
    cyc(2'b11, CLS_LOAD,  4'd2, 4'd0, 4'd0, CLS_STORE, 4'd0, 4'd0, 4'd0, 2'b10, "R6");
    cyc(2'b11, CLS_INT,   4'd0, 4'd0, 4'd0, CLS_PREF,  4'd0, 4'd0, 4'd0, 2'b00, "R6");
    cyc(2'b11, CLS_PREF,  4'd0, 4'd0, 4'd0, CLS_XFER,  4'd3, 4'd0, 4'd0, 2'b10, "R6");
    cyc(2'b10, CLS_LOAD,  4'd0, 4'd0, 4'd0, CLS_LOAD,  4'd0, 4'd0, 4'd0, 2'b00, "R6");
    idle(6);

    // R7: same-cycle dependency between lanes
    cyc(2'b11, CLS_INT, 4'd4, 4'd0, 4'd0, CLS_INT, 4'd5, 4'd0, 4'd4, 2'b10, "R7");
    idle(3);
    cyc(2'b11, CLS_STORE,   4'd4, 4'd0, 4'd0, CLS_INT, 4'd0, 4'd4, 4'd0, 2'b00, "R3");
    cyc(2'b11, CLS_UNKNOWN, 4'd6, 4'd0, 4'd0, CLS_INT, 4'd0, 4'd6, 4'd0, 2'b10, "R4");
    cyc(2'b11, CLS_INT,     4'd0, 4'd0, 4'd0, CLS_INT, 4'd0, 4'd0, 4'd0, 2'b00, "R5");

    // R8: younger lane waits behind a held older lane
    cyc(2'b01, CLS_IMUL, 4'd7, 4'd0, 4'd0, CLS_INT, 4'd0, 4'd0, 4'd0, 2'b00, "R8");
    cyc(2'b11, CLS_INT,  4'd0, 4'd7, 4'd0, CLS_INT, 4'd0, 4'd1, 4'd2, 2'b11, "R8");
    idle(5);

    // R9: invalid lanes
    cyc(2'b01, CLS_FP_SQRT, 4'd8, 4'd0, 4'd0, CLS_INT, 4'd0, 4'd0, 4'd0, 2'b00, "R9");
    cyc(2'b10, CLS_LOAD, 4'd0, 4'd8, 4'd0, CLS_LOAD, 4'd9, 4'd0, 4'd0, 2'b00, "R9");
    cyc(2'b01, CLS_INT,  4'd0, 4'd8, 4'd0, CLS_INT, 4'd0, 4'd8, 4'd0, 2'b01, "R9");
    idle(16);
    cyc(2'b01, CLS_INT,  4'd0, 4'd9, 4'd0, CLS_INT, 4'd0, 4'd0, 4'd0, 2'b00, "R9");

    // R10: reload replaces remaining count
    cyc(2'b01, CLS_IDIV, 4'd10, 4'd0, 4'd0, CLS_INT, 4'd0, 4'd0, 4'd0, 2'b00, "R10");
    cyc(2'b01, CLS_INT,  4'd0, 4'd10, 4'd0, CLS_INT, 4'd0, 4'd0, 4'd0, 2'b01, "R10");
    cyc(2'b01, CLS_INT,  4'd10, 4'd0, 4'd0, CLS_INT, 4'd0, 4'd0, 4'd0, 2'b00, "R10");
    cyc(2'b01, CLS_INT,  4'd0, 4'd10, 4'd0, CLS_INT, 4'd0, 4'd0, 4'd0, 2'b01, "R10");
    cyc(2'b01, CLS_INT,  4'd0, 4'd10, 4'd0, CLS_INT, 4'd0, 4'd0, 4'd0, 2'b00, "R10");
    // R10: younger lane wins on same destination
    cyc(2'b11, CLS_IDIV, 4'd11, 4'd0, 4'd0, CLS_INT, 4'd11, 4'd0, 4'd0, 2'b00, "R10");
    cyc(2'b01, CLS_INT,  4'd0, 4'd11, 4'd0, CLS_INT, 4'd0, 4'd0, 4'd0, 2'b01, "R10");
    cyc(2'b01, CLS_INT,  4'd0, 4'd11, 4'd0, CLS_INT, 4'd0, 4'd0, 4'd0, 2'b00, "R10");

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule